// File: doc/BRIEF.md
# Unaligned Burst Splitter

This block sits on the requesting side of a memory-mapped bus. It turns a request for N bytes at any byte address into a short series of burst commands. Each command is aligned to its own beat size, so the responder downstream never sees an unaligned burst. The series has up to three parts, always in the same order:

- a head of byte-wide beats that reaches the first word boundary;
- a body of full-word beats;
- a tail of byte-wide beats for the bytes left over after the last full word.

Any part with zero beats is left out. A body longer than the burst-length limit is issued as several consecutive incrementing bursts.

Wrapping requests are never split. A legal wrapping request passes through as one word-wide command. An illegal one is refused with a one-cycle error pulse and produces no command.

Requests and commands both use a valid/ready handshake. One request is in flight at a time. A one-cycle done pulse marks the handoff of the final command of a request.

Top module: `burst_align_splitter`

## Requirements
- R1: `req_ready` is high exactly when no command of an earlier request is still waiting to be handed off. A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- R2: For an incrementing request at a start address `a` that is not a multiple of 4, the first command is the head. It uses byte beats (`cmd_size`=0) at address `a`, with `cmd_len` = min(4 - a mod 4, N) - 1.
- R3: The body uses word beats (`cmd_size`=2) and `cmd_burst`=1 (incrementing). It starts at the first multiple of 4 at or after `a` and covers (N - head bytes) / 4 words.
- R4: The tail uses byte beats (`cmd_size`=0) and `cmd_burst`=1. It covers (N - head bytes) mod 4 bytes and starts right after the last body byte.
- R5: Commands come out in the order head, body, tail, and every part with zero beats is skipped. An incrementing request whose address and length are both multiples of 4 produces exactly one command.
- R6: No body command carries more than 256 beats. A longer body is issued as consecutive 256-beat commands, each address advancing by 1024 bytes, followed by one command for the remainder.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the command fields stay unchanged in the next cycle.
- R8: `done` is high for one cycle, in the same cycle as the handoff of the final command of a request. A request with N = 0 produces no command, and `done` is high in the cycle it is taken.
- R9: A wrapping request (`req_wrap`=1) is legal only when all three hold: `a` is a multiple of 4, N is a multiple of 4, and N/4 is 2, 4, 8 or 16. A legal one yields one command with `cmd_burst`=2, `cmd_size`=2 and `cmd_len` = N/4 - 1. An illegal one raises `err` in the cycle it is taken, gives no command and no `done`, and leaves `req_ready` high.
- R10: `cmd_len` is the beat count minus one. `cmd_size` 0 means 1 byte per beat and 2 means 4 bytes per beat. `cmd_burst` 1 means incrementing and 2 means wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Start byte address |
| req_nbytes | input | 16 | Number of bytes to move |
| req_wrap | input | 1 | Request is a wrapping burst |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command taken by downstream |
| cmd_addr | output | 32 | Command start address |
| cmd_size | output | 3 | Beat size code (0 byte, 2 word) |
| cmd_len | output | 8 | Beats minus one |
| cmd_burst | output | 2 | Burst kind (1 incrementing, 2 wrapping) |
| done | output | 1 | Final command of the request handed off |
| err | output | 1 | Illegal wrapping request refused |

## Verification
Two things can happen in the same cycle: the final command handoff (`done`) and a fresh request already waiting on `req_valid`.

To provoke this, the bench keeps an illegal wrapping request asserted for the whole time an earlier request is still emitting commands. If that request were taken early, `err` would fire at once.

Two checks judge the result. In the final handoff cycle, `done` must be high, while `req_ready` and `err` stay low. In the very next cycle, `req_ready` must be high and `err` must pulse.

The offset and length sweeps also run under a pseudo-random `cmd_ready` stall pattern. This places the final handoff at varying distances from the moment the request was taken.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 16;
    localparam int WORD_BYTES = 4;
    localparam int MAX_BEATS  = 256;

    localparam int OFS_W         = $clog2(WORD_BYTES);
    localparam int LEN_W         = $clog2(MAX_BEATS);
    localparam int SIZE_W        = 3;
    localparam int WORD_SIZE_ENC = OFS_W;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] BURST_WRAP = 2'b10;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HEAD,
        PH_BODY,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        addr_t             addr;
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  len;
        logic [1:0]        burst;
    } cmd_t;

    typedef struct packed {
        addr_t addr;
        cnt_t  head;
        cnt_t  words;
        cnt_t  tail;
        logic  wrap;
        logic  bad;
        logic  empty;
    } plan_t;

    function automatic logic wrap_beats_ok(input cnt_t w);
        return (w == cnt_t'(2)) || (w == cnt_t'(4)) ||
               (w == cnt_t'(8)) || (w == cnt_t'(16));
    endfunction

endpackage

// File: rtl/bas_planner.sv
module bas_planner
    import bas_pkg::*;
(
    input  addr_t addr,
    input  cnt_t  nbytes,
    input  logic  wrap,
    output plan_t plan
);

    logic [OFS_W-1:0] ofs;
    cnt_t             gap;
    cnt_t             head;
    cnt_t             rest;

    always_comb begin
        ofs  = addr[OFS_W-1:0];
        gap  = (ofs == '0) ? '0 : cnt_t'(WORD_BYTES) - cnt_t'(ofs);
        head = (gap > nbytes) ? nbytes : gap;
        rest = nbytes - head;

        plan       = '0;
        plan.addr  = addr;
        plan.wrap  = wrap;
        plan.empty = (nbytes == '0);

        if (wrap) begin
            plan.head  = '0;
            plan.words = nbytes >> OFS_W;
            plan.tail  = '0;
            plan.bad   = (ofs != '0) || (nbytes[OFS_W-1:0] != '0) ||
                         !wrap_beats_ok(nbytes >> OFS_W);
        end else begin
            plan.head  = head;
            plan.words = rest >> OFS_W;
            plan.tail  = rest & cnt_t'(WORD_BYTES - 1);
            plan.bad   = 1'b0;
        end
    end

endmodule

// File: rtl/bas_sequencer.sv
module bas_sequencer
    import bas_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  plan_t plan,
    output logic  busy,
    output cmd_t  cmd,
    output logic  cmd_valid,
    input  logic  cmd_ready,
    output logic  last
);

    phase_e phase_q;
    addr_t  addr_q;
    cnt_t   head_q;
    cnt_t   words_q;
    cnt_t   tail_q;
    logic   wrap_q;

    cnt_t   chunk;
    cnt_t   words_left;
    phase_e phase_after;
    phase_e phase_first;
    addr_t  step;
    logic   fire;

    always_comb begin
        chunk      = (words_q > cnt_t'(MAX_BEATS)) ? cnt_t'(MAX_BEATS) : words_q;
        words_left = words_q - chunk;

        if (plan.head != '0)       phase_first = PH_HEAD;
        else if (plan.words != '0) phase_first = PH_BODY;
        else if (plan.tail != '0)  phase_first = PH_TAIL;
        else                       phase_first = PH_IDLE;

        cmd         = '0;
        cmd.addr    = addr_q;
        cmd.burst   = BURST_INCR;
        step        = '0;
        phase_after = PH_IDLE;

        case (phase_q)
            PH_HEAD: begin
                cmd.size    = '0;
                cmd.len     = LEN_W'(head_q - cnt_t'(1));
                step        = addr_t'(head_q);
                phase_after = (words_q != '0) ? PH_BODY :
                              (tail_q != '0)  ? PH_TAIL : PH_IDLE;
            end
            PH_BODY: begin
                cmd.size    = SIZE_W'(WORD_SIZE_ENC);
                cmd.len     = LEN_W'(chunk - cnt_t'(1));
                cmd.burst   = wrap_q ? BURST_WRAP : BURST_INCR;
                step        = addr_t'(chunk) << OFS_W;
                phase_after = (words_left != '0) ? PH_BODY :
                              (tail_q != '0)     ? PH_TAIL : PH_IDLE;
            end
            PH_TAIL: begin
                cmd.size    = '0;
                cmd.len     = LEN_W'(tail_q - cnt_t'(1));
                step        = addr_t'(tail_q);
                phase_after = PH_IDLE;
            end
            default: begin
                phase_after = PH_IDLE;
            end
        endcase
    end

    assign busy      = (phase_q != PH_IDLE);
    assign cmd_valid = busy;
    assign fire      = cmd_valid && cmd_ready;
    assign last      = (phase_after == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            head_q  <= '0;
            words_q <= '0;
            tail_q  <= '0;
            wrap_q  <= 1'b0;
        end else if (load && !busy) begin
            phase_q <= phase_first;
            addr_q  <= plan.addr;
            head_q  <= plan.head;
            words_q <= plan.words;
            tail_q  <= plan.tail;
            wrap_q  <= plan.wrap;
        end else if (fire) begin
            phase_q <= phase_after;
            addr_q  <= addr_q + step;
            if (phase_q == PH_BODY) begin
                words_q <= words_left;
            end
        end
    end

    // R7: an offered command is held until taken
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd));

    // R3: word-wide commands start on a word boundary
    p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd.size == SIZE_W'(WORD_SIZE_ENC) |-> cmd.addr[OFS_W-1:0] == '0);

    // R2: byte-wide segments never reach a full word
    p_narrow_short_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd.size == '0 |-> cmd.len <= LEN_W'(WORD_BYTES - 2));

endmodule

// File: rtl/burst_align_splitter.sv
module burst_align_splitter
    import bas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_nbytes,
    input  logic              req_wrap,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [SIZE_W-1:0] cmd_size,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [1:0]        cmd_burst,
    output logic              done,
    output logic              err
);

    plan_t plan;
    cmd_t  cmd;
    logic  busy;
    logic  last;
    logic  req_fire;
    logic  load;

    bas_planner u_planner (
        .addr   (req_addr),
        .nbytes (req_nbytes),
        .wrap   (req_wrap),
        .plan   (plan)
    );

    assign req_ready = !busy;
    assign req_fire  = req_valid && req_ready;
    assign load      = req_fire && !plan.bad && !plan.empty;

    bas_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .plan      (plan),
        .busy      (busy),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .last      (last)
    );

    assign cmd_addr  = cmd.addr;
    assign cmd_size  = cmd.size;
    assign cmd_len   = cmd.len;
    assign cmd_burst = cmd.burst;

    assign err  = req_fire && plan.bad;
    assign done = (cmd_valid && cmd_ready && last) ||
                  (req_fire && plan.empty && !plan.bad);

    // R9: a refused request leaves nothing to issue
    p_err_no_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> !cmd_valid);

    // R9: refusal and completion never coincide
    p_err_not_done_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !done);

    // R8: after the final handoff the block is idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done && cmd_valid && cmd_ready |=> !cmd_valid && req_ready);

    // R1: a request is never taken while a command is pending
    p_no_take_busy_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !(cmd_ready && last) |=> !req_ready);

endmodule

// File: tb/burst_align_splitter_tb.sv
module burst_align_splitter_tb;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [15:0] req_nbytes;
    logic        req_wrap;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [2:0]  cmd_size;
    logic [7:0]  cmd_len;
    logic [1:0]  cmd_burst;
    logic        done;
    logic        err;

    always #(CLK_P / 2) clk = ~clk;

    burst_align_splitter u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_nbytes (req_nbytes),
        .req_wrap   (req_wrap),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_size   (cmd_size),
        .cmd_len    (cmd_len),
        .cmd_burst  (cmd_burst),
        .done       (done),
        .err        (err)
    );

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [15:0] lfsr     = 16'hACE1;

    logic [31:0] e_addr [16];
    int          e_size [16];
    int          e_len  [16];
    int          e_burst[16];
    string       e_tag  [16];
    int          n_exp;
    bit          e_bad;
    bit          e_empty;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] a, input int sz, input int beats,
                        input int bu, input string tag);
        e_addr[n_exp]  = a;
        e_size[n_exp]  = sz;
        e_len[n_exp]   = beats - 1;
        e_burst[n_exp] = bu;
        e_tag[n_exp]   = tag;
        n_exp++;
    endtask

    task automatic build_exp(input logic [31:0] a, input int n, input bit w);
        int off;
        int head;
        int words;
        int tail;
        int beats;
        logic [31:0] p;
        n_exp   = 0;
        e_bad   = 0;
        e_empty = (n == 0);
        off     = int'(a % 4);
        if (w) begin
            beats = n / 4;
            e_bad = (off != 0) || (n % 4 != 0) ||
                    !(beats == 2 || beats == 4 || beats == 8 || beats == 16);
            if (!e_bad) push(a, 2, beats, 2, "R9");
        end else begin
            head = (off == 0) ? 0 : 4 - off;
            if (head > n) head = n;
            words = (n - head) / 4;
            tail  = (n - head) % 4;
            p     = a;
            if (head > 0) begin
                push(p, 0, head, 1, "R2");
                p = p + head;
            end
            while (words > 0) begin
                beats = (words > 256) ? 256 : words;
                push(p, 2, beats, 1, (words > 256 || n_exp > 1) ? "R6" : "R3");
                p     = p + 32'(beats * 4);
                words = words - beats;
            end
            if (tail > 0) push(p, 0, tail, 1, "R4");
        end
    endtask

    function automatic bit next_ready(input int mode);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return (mode == 0) ? 1'b1 : lfsr[0];
    endfunction

    task automatic run_req(input logic [31:0] a, input int n, input bit w,
                           input int mode, input bit overlap);
        int          k;
        int          guard;
        bit          held;
        logic [31:0] h_addr;
        logic [2:0]  h_size;
        logic [7:0]  h_len;
        logic [1:0]  h_burst;
        bit          rdy;
        build_exp(a, n, w);
        @(negedge clk);
        req_addr   = a;
        req_nbytes = 16'(n);
        req_wrap   = w;
        req_valid  = 1'b1;
        cmd_ready  = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        chk(err == e_bad, "R9", "err at take", err, e_bad);
        chk(done == (e_empty && !e_bad), "R8", "done at take", done, e_empty && !e_bad);
        @(negedge clk);
        if (overlap) begin
            req_addr   = 32'h201;
            req_nbytes = 16'd16;
            req_wrap   = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        k     = 0;
        held  = 0;
        guard = 0;
        while (k < n_exp && guard < 4000) begin
            guard++;
            rdy       = next_ready(mode);
            cmd_ready = rdy;
            #1;
            chk(cmd_valid == 1'b1, "R5", "command offered", cmd_valid, 1);
            chk(req_ready == 1'b0, "R1", "busy blocks request", req_ready, 0);
            if (overlap) chk(err == 1'b0, "R1", "no early take", err, 0);
            if (held) begin
                chk(cmd_addr == h_addr && cmd_size == h_size && cmd_len == h_len &&
                    cmd_burst == h_burst, "R7", "held command changed",
                    {cmd_addr, cmd_len}, {h_addr, h_len});
            end
            if (rdy) begin
                chk(cmd_addr == e_addr[k], e_tag[k], "addr", cmd_addr, e_addr[k]);
                chk(int'(cmd_size) == e_size[k], "R10", "size", cmd_size, e_size[k]);
                chk(int'(cmd_len) == e_len[k], e_tag[k], "len", cmd_len, e_len[k]);
                chk(int'(cmd_burst) == e_burst[k], "R10", "burst", cmd_burst, e_burst[k]);
                chk(done == (k == n_exp - 1), "R8", "done at handoff", done, k == n_exp - 1);
                held = 0;
                k++;
            end else begin
                chk(done == 1'b0, "R8", "no done while stalled", done, 0);
                held    = 1;
                h_addr  = cmd_addr;
                h_size  = cmd_size;
                h_len   = cmd_len;
                h_burst = cmd_burst;
            end
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        #1;
        chk(cmd_valid == 1'b0, "R5", "no extra command", cmd_valid, 0);
        chk(req_ready == 1'b1, "R1", "ready after end", req_ready, 1);
        if (overlap) begin
            chk(err == 1'b1, "R9", "waiting request taken next cycle", err, 1);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(cmd_valid == 1'b0, "R9", "refused request gives no command", cmd_valid, 0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_addr   = '0;
        req_nbytes = '0;
        req_wrap   = 1'b0;
        cmd_ready  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(cmd_valid == 1'b0, "R1", "reset no command", cmd_valid, 0);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(done == 1'b0 && err == 1'b0, "R8", "reset pulses low", {done, err}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4 R5: offsets and lengths sweep, with and without stalls
        for (int off = 0; off < 8; off++) begin
            for (int n = 0; n <= 40; n++) begin
                run_req(32'h1000 + 32'(off), n, 1'b0, (n + off) % 2, 1'b0);
            end
        end

        // R6: long bodies split at 256 beats
        run_req(32'h1001, 1100, 1'b0, 0, 1'b0);
        run_req(32'h2000, 2048, 1'b0, 1, 1'b0);
        run_req(32'h3003, 1030, 1'b0, 1, 1'b0);

        // R9: wrapping requests over offsets and lengths
        for (int off = 0; off < 4; off++) begin
            for (int n = 0; n <= 72; n += 4) begin
                run_req(32'h4000 + 32'(off), n, 1'b1, n % 8 == 0 ? 0 : 1, 1'b0);
            end
        end
        run_req(32'h4100, 6, 1'b1, 0, 1'b0);
        run_req(32'h4100, 128, 1'b1, 0, 1'b0);

        // R8 R1: final handoff with a request already waiting
        run_req(32'h5001, 16, 1'b0, 0, 1'b1);
        run_req(32'h5002, 13, 1'b0, 1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule